// File: doc/BRIEF.md
# Auto-Refresh Scheduler for an SDRAM Controller

This block sits inside an SDRAM controller and decides when an auto-refresh command goes out. A down-counter measures the average refresh interval, whose length in clocks is the interval in picoseconds divided by the clock period in picoseconds (15.625 µs by default). Each expiry adds one refresh to a bounded count of owed refreshes. While anything is owed, the block raises a request. The controller's arbiter answers with a grant. A refresh is sent only when the grant arrives while all banks report idle, and it is sent as a single-cycle pulse.

After each refresh, a busy window covers the refresh cycle time, and no further request is made while it lasts. The owed count saturates at a parameter limit. When one more interval expires with the count already at that limit, an overdue flag is raised.

While the device is in self-refresh, the device refreshes itself. The scheduler therefore clears its owed count, holds its timer and stays quiet. When self-refresh ends, the scheduler starts again with full credit and a fresh interval. Precharging banks, driving the command pins and entering self-refresh are handled by other parts of the controller.

Top module: `rfsh_scheduler`

## Requirements
- R1: After synchronous reset, req_o, ref_cmd_o, busy_o and overdue_o are 0 and owed_o is 0.
- R2: An interval tick occurs every INT_CYC = REF_INTERVAL_PS / CLK_PERIOD_PS clock edges. The first tick is on the INT_CYC-th edge after reset is released. Each tick adds one to owed_o. req_o rises on the same edge that owed_o becomes non-zero, unless busy_o or self_ref_i holds it low.
- R3: ref_cmd_o is high for exactly one cycle. It follows an edge at which req_o, grant_i and banks_idle_i were all 1 and self_ref_i was 0.
- R4: grant_i has no effect while banks_idle_i is 0 or req_o is 0. In that case no command is issued and owed_o is unchanged.
- R5: Each command lowers owed_o by one, on the same edge that ref_cmd_o rises. When owed_o is 0, req_o is 0.
- R6: busy_o is high for TRFC_CYC cycles, starting with the command cycle. req_o is 0 while busy_o is 1. With a grant held, consecutive commands are exactly TRFC_CYC+1 cycles apart.
- R7: owed_o never exceeds OWED_MAX. A tick at OWED_MAX leaves owed_o at OWED_MAX.
- R8: overdue_o is set by a tick that arrives while owed_o is already OWED_MAX and no command is issued on that edge. It is cleared by the next command, and it is only ever 1 while owed_o equals OWED_MAX.
- R9: While self_ref_i is 1, owed_o and overdue_o are cleared, the interval timer is held at its start value, req_o is 0, and grant_i is ignored.
- R10: After self_ref_i falls, the next tick comes exactly INT_CYC edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle_i | input | 1 | All banks closed and idle |
| grant_i | input | 1 | Arbiter grants the command slot to refresh |
| self_ref_i | input | 1 | Device is in self-refresh |
| req_o | output | 1 | Refresh requested (owed count non-zero, not busy) |
| ref_cmd_o | output | 1 | One-cycle auto-refresh command pulse |
| busy_o | output | 1 | Refresh cycle time window in progress |
| overdue_o | output | 1 | Owed count hit its limit and another interval expired |
| owed_o | output | $clog2(OWED_MAX+1) | Number of refreshes owed |

## Verification
A timer that is off by one shows up at once as req_o rising one edge early or late after reset or after self-refresh exit. The bench therefore samples those edges exactly. A credit counter that is wrong in either direction appears within one interval: owed_o is too high or too low, commands are missing or extra during a held grant, or overdue_o is asserted at the wrong tick. A busy window of the wrong length changes the spacing of back-to-back commands, which the scoreboard compares against exact predicted cycles.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Number of clocks in one average refresh interval.
  function automatic int rf_cycles(input int interval_ps, input int period_ps);
    return interval_ps / period_ps;
  endfunction

  // Width that can hold the values 0..n.
  function automatic int rf_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INT_CYC = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);
  localparam int TW = rfsh_pkg::rf_width(INT_CYC - 1);
  localparam logic [TW-1:0] START = TW'(INT_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= START;
    end else if (cnt_q == '0) begin
      cnt_q <= START;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int OWED_MAX = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  clr_i,
  input  logic                                  tick_i,
  input  logic                                  take_i,
  output logic [rfsh_pkg::rf_width(OWED_MAX)-1:0] owed_o,
  output logic [rfsh_pkg::rf_width(OWED_MAX)-1:0] owed_nxt_o,
  output logic                                  overdue_o
);
  localparam int OW = rfsh_pkg::rf_width(OWED_MAX);
  localparam logic [OW-1:0] LIMIT = OW'(OWED_MAX);

  logic overdue_nxt;

  always_comb begin
    owed_nxt_o  = owed_o;
    overdue_nxt = overdue_o;
    if (clr_i) begin
      owed_nxt_o  = '0;
      overdue_nxt = 1'b0;
    end else begin
      unique case ({tick_i, take_i})
        2'b10: begin
          if (owed_o == LIMIT) overdue_nxt = 1'b1;
          else                 owed_nxt_o  = owed_o + 1'b1;
        end
        2'b01: begin
          owed_nxt_o  = owed_o - 1'b1;
          overdue_nxt = 1'b0;
        end
        2'b11: overdue_nxt = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_o    <= '0;
      overdue_o <= 1'b0;
    end else begin
      owed_o    <= owed_nxt_o;
      overdue_o <= overdue_nxt;
    end
  end
endmodule

// File: rtl/rfsh_rfc_window.sv
module rfsh_rfc_window #(
  parameter int TRFC_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic busy_nxt_o
);
  localparam int CW = rfsh_pkg::rf_width(TRFC_CYC - 1);
  localparam logic [CW-1:0] SPAN = CW'(TRFC_CYC - 1);

  logic [CW-1:0] left_q;

  assign busy_nxt_o = start_i || (busy_o && (left_q != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      left_q <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      left_q <= SPAN;
    end else if (busy_o) begin
      if (left_q == '0) busy_o <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler #(
  parameter int CLK_PERIOD_PS   = 10000,
  parameter int REF_INTERVAL_PS = 15625000,
  parameter int TRFC_CYC        = 6,
  parameter int OWED_MAX        = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    banks_idle_i,
  input  logic                                    grant_i,
  input  logic                                    self_ref_i,
  output logic                                    req_o,
  output logic                                    ref_cmd_o,
  output logic                                    busy_o,
  output logic                                    overdue_o,
  output logic [rfsh_pkg::rf_width(OWED_MAX)-1:0] owed_o
);
  localparam int INT_CYC = rfsh_pkg::rf_cycles(REF_INTERVAL_PS, CLK_PERIOD_PS);
  localparam int OW      = rfsh_pkg::rf_width(OWED_MAX);

  logic          tick;
  logic          issue;
  logic          busy_nxt;
  logic [OW-1:0] owed_nxt;

  assign issue = req_o && grant_i && banks_idle_i && !self_ref_i;

  rfsh_interval_timer #(.INT_CYC(INT_CYC)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .hold_i (self_ref_i),
    .tick_o (tick)
  );

  rfsh_credit #(.OWED_MAX(OWED_MAX)) credit_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (self_ref_i),
    .tick_i     (tick),
    .take_i     (issue),
    .owed_o     (owed_o),
    .owed_nxt_o (owed_nxt),
    .overdue_o  (overdue_o)
  );

  rfsh_rfc_window #(.TRFC_CYC(TRFC_CYC)) window_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (issue),
    .busy_o     (busy_o),
    .busy_nxt_o (busy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o     <= 1'b0;
      ref_cmd_o <= 1'b0;
    end else begin
      req_o     <= (owed_nxt != '0) && !busy_nxt && !self_ref_i;
      ref_cmd_o <= issue;
    end
  end
endmodule

// File: rtl/rfsh_scheduler_chk.sv
module rfsh_scheduler_chk #(
  parameter int OWED_MAX = 8
) (
  input logic                                    clk,
  input logic                                    rst,
  input logic                                    banks_idle_i,
  input logic                                    grant_i,
  input logic                                    self_ref_i,
  input logic                                    req_o,
  input logic                                    ref_cmd_o,
  input logic                                    busy_o,
  input logic                                    overdue_o,
  input logic [rfsh_pkg::rf_width(OWED_MAX)-1:0] owed_o
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |=> !ref_cmd_o);

  a_r3_cmd_needs_handshake: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> $past(req_o && grant_i && banks_idle_i && !self_ref_i));

  a_r6_busy_with_cmd: assert property (@(posedge clk) disable iff (rst)
    ref_cmd_o |-> busy_o);

  a_r6_no_req_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !req_o);

  a_r7_owed_bound: assert property (@(posedge clk) disable iff (rst)
    owed_o <= OWED_MAX);

  a_r8_overdue_at_limit: assert property (@(posedge clk) disable iff (rst)
    overdue_o |-> (owed_o == OWED_MAX));

  a_r9_selfref_quiet: assert property (@(posedge clk) disable iff (rst)
    self_ref_i |=> (!req_o && owed_o == 0 && !overdue_o));

  a_r5_req_needs_credit: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (owed_o != 0));
endmodule

bind rfsh_scheduler rfsh_scheduler_chk #(.OWED_MAX(OWED_MAX)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .banks_idle_i (banks_idle_i),
  .grant_i      (grant_i),
  .self_ref_i   (self_ref_i),
  .req_o        (req_o),
  .ref_cmd_o    (ref_cmd_o),
  .busy_o       (busy_o),
  .overdue_o    (overdue_o),
  .owed_o       (owed_o)
);

// File: tb/rfsh_scheduler_tb_top.sv
`timescale 1ns/1ps
module rfsh_scheduler_tb_top;
  localparam int INT  = 100;
  localparam int TRFC = 6;
  localparam int OMAX = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic banks_idle_i = 1'b0;
  logic grant_i = 1'b0;
  logic self_ref_i = 1'b0;
  logic req_o, ref_cmd_o, busy_o, overdue_o;
  logic [3:0] owed_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  rfsh_scheduler #(
    .CLK_PERIOD_PS(10000), .REF_INTERVAL_PS(1000000),
    .TRFC_CYC(TRFC), .OWED_MAX(OMAX)
  ) dut_i (
    .clk(clk), .rst(rst), .banks_idle_i(banks_idle_i), .grant_i(grant_i),
    .self_ref_i(self_ref_i), .req_o(req_o), .ref_cmd_o(ref_cmd_o),
    .busy_o(busy_o), .overdue_o(overdue_o), .owed_o(owed_o)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic expect_cmd(input int at);
    exp_q.push_back(at);
  endtask

  // Scoreboard monitor: every command must match the next predicted cycle.
  always @(negedge clk) begin
    int e;
    if (!rst && ref_cmd_o) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected refresh: actual=cycle %0d expected=none", cyc);
      end else begin
        e = exp_q.pop_front();
        if (e != cyc) begin
          fails++;
          $display("FAIL R3/R6 refresh timing: actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!req_o && !ref_cmd_o && !busy_o && !overdue_o && owed_o == 0, "R1 reset",
        {req_o, ref_cmd_o, busy_o, overdue_o, owed_o}, 0);
    rst = 1'b0;

    // R2 first tick exactly INT edges after release
    wait_to(INT - 1);
    chk(req_o == 0, "R2 no req before tick", req_o, 0);
    wait_to(INT);
    chk(req_o == 1, "R2 req at tick", req_o, 1);
    chk(owed_o == 1, "R2 owed at tick", owed_o, 1);

    // R4 grant ignored while banks busy
    grant_i = 1'b1; banks_idle_i = 1'b0;
    wait_to(INT + 5);
    chk(owed_o == 1, "R4 owed kept (banks busy)", owed_o, 1);
    chk(req_o == 1, "R4 req kept (banks busy)", req_o, 1);

    // R3 / R5 / R6 single command
    banks_idle_i = 1'b1;
    expect_cmd(INT + 6);
    wait_to(INT + 6);
    chk(ref_cmd_o == 1, "R3 cmd pulse", ref_cmd_o, 1);
    chk(owed_o == 0, "R5 owed decremented", owed_o, 0);
    chk(req_o == 0, "R5 req dropped", req_o, 0);
    chk(busy_o == 1, "R6 busy with cmd", busy_o, 1);
    wait_to(INT + 7);
    chk(ref_cmd_o == 0, "R3 pulse one cycle", ref_cmd_o, 0);
    wait_to(INT + 6 + TRFC - 1);
    chk(busy_o == 1, "R6 busy last cycle", busy_o, 1);
    wait_to(INT + 6 + TRFC);
    chk(busy_o == 0, "R6 busy ended", busy_o, 0);

    // R4 grant with no credit: nothing happens (monitor flags any command)
    wait_to(150);
    chk(owed_o == 0 && req_o == 0, "R4 grant without req", owed_o, 0);
    grant_i = 1'b0;

    // R7 / R8 accumulate without grant
    wait_to(9 * INT);
    chk(owed_o == OMAX, "R7 owed reaches limit", owed_o, OMAX);
    wait_to(10 * INT - 1);
    chk(owed_o == OMAX, "R7 owed saturated", owed_o, OMAX);
    chk(overdue_o == 0, "R8 not yet overdue", overdue_o, 0);
    wait_to(10 * INT);
    chk(overdue_o == 1, "R8 overdue set", overdue_o, 1);
    chk(owed_o == OMAX, "R7 owed held at limit", owed_o, OMAX);

    // R6 back-to-back drain with held grant
    grant_i = 1'b1;
    for (int k = 0; k < OMAX; k++) expect_cmd(10 * INT + 1 + k * (TRFC + 1));
    wait_to(10 * INT + 1);
    chk(overdue_o == 0, "R8 overdue cleared by cmd", overdue_o, 0);
    chk(owed_o == OMAX - 1, "R5 owed after first drain cmd", owed_o, OMAX - 1);
    wait_to(1060);
    chk(owed_o == 0 && req_o == 0, "R5 drained", owed_o, 0);
    chk(exp_q.size() == 0, "R6 all drain cmds seen", exp_q.size(), 0);
    grant_i = 1'b0;

    // R9 self-refresh clears credit and ignores grant
    wait_to(11 * INT);
    chk(owed_o == 1 && req_o == 1, "R2 periodic tick", owed_o, 1);
    wait_to(1150);
    self_ref_i = 1'b1; grant_i = 1'b1;
    wait_to(1151);
    chk(owed_o == 0 && req_o == 0, "R9 credit cleared", owed_o, 0);
    wait_to(1450);
    chk(owed_o == 0 && req_o == 0 && !overdue_o, "R9 timer held", owed_o, 0);
    self_ref_i = 1'b0; grant_i = 1'b0;

    // R10 fresh interval after exit
    wait_to(1450 + INT - 1);
    chk(req_o == 0, "R10 no tick early", req_o, 0);
    wait_to(1450 + INT);
    chk(req_o == 1 && owed_o == 1, "R10 tick after exit", owed_o, 1);

    chk(exp_q.size() == 0, "R3 no missing cmds", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule